// File: doc/BRIEF.md
# Watchdog and Countdown Timer

This block is an eight-bit down counter with two jobs, chosen by a two-bit mode field. It steps once for each enable tick of one of four tick inputs, so it can run at four rates from a single system clock. As a watchdog, it runs down once from the value that software writes. When it expires it raises a flag that software cannot clear by writing. It also raises the interrupt and a reset pulse on the output. The pulse is shorter when the fastest tick is selected.

As a countdown timer, it sets its own flag each time it expires, loads the programmed value again and keeps running. The interrupt from the countdown flag has two forms. In level form it stays active while the flag is set. In pulsed form it lasts a fixed number of cycles, and clearing the flag cuts it short.

Software writes the count value and the control word through strobes. A status-read strobe, a countdown-clear strobe and the four tick enables are the other inputs. The bus interface is outside the block. The first period after a write can be up to one tick shorter than the programmed value, because the ticks run free of the write.

Top module: `wct_timer`

## Requirements
- R1: A write on `val_wr` loads `val_wdata` into the counter and the reload register. Each selected tick with a nonzero count and an enabled mode lowers the count by one. The counter expires on the tick that finds the count at 1, so a value of n expires on the n-th selected tick after the write.
- R2: The stored source field s (0 to 3) selects `tick_en[s]` as the only tick that steps the counter. Pulses on the other three tick inputs have no effect on the count or the flags.
- R3: A count of 0 keeps the counter stopped in every mode, and neither flag is set.
- R4: Mode 2'b10 is the watchdog. On expiry `wd_flag` goes to 1 in the next cycle and the counter stays at 0, so it does not expire again until a new value is written. Modes 2'b00 and 2'b11 hold the counter.
- R5: `wd_flag` is cleared only by `val_wr` or `stat_rd`. A `cd_clr` strobe leaves it unchanged.
- R6: A watchdog expiry drives `wd_rst` high from the next cycle. It stays high for RST_FAST_CYC cycles when the stored source is 0 and for RST_SLOW_CYC cycles for sources 1 to 3.
- R7: Mode 2'b01 is the countdown timer. On expiry `cd_flag` goes to 1 and the counter reloads the written value n, so the flag fires again every n selected ticks.
- R8: `cd_flag` is cleared only by `cd_clr`. A `stat_rd` strobe leaves it unchanged.
- R9: When the stored pulse bit is 0, `irq` is high whenever `wd_flag` is 1, or whenever `cd_flag` is 1 and the stored countdown enable bit is 1.
- R10: When the stored pulse bit is 1, a countdown expiry drives the countdown part of `irq` for PULSE_CYC cycles, provided the enable bit is 1. A `cd_clr` ends that pulse in the next cycle. With the enable bit at 0, `cd_flag` never drives `irq`.
- R11: After a synchronous reset (`rst_n` low), both flags, `irq` and `wd_rst` are 0, the count is 0 and the mode is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_wr | input | 1 | Strobe that stores the four control fields |
| ctl_mode | input | 2 | Mode: 01 countdown, 10 watchdog, other values hold |
| ctl_src | input | 2 | Index of the tick input that steps the counter |
| ctl_pulse | input | 1 | 1 selects the pulsed form of the countdown interrupt |
| ctl_cd_ie | input | 1 | Enables the countdown flag onto the interrupt |
| val_wr | input | 1 | Strobe that loads the count value |
| val_wdata | input | 8 | Count value n |
| stat_rd | input | 1 | Status-read strobe, clears the watchdog flag |
| cd_clr | input | 1 | Strobe that clears the countdown flag |
| tick_en | input | 4 | One-cycle enables of the four source rates |
| wd_flag | output | 1 | Watchdog expiry flag |
| cd_flag | output | 1 | Countdown expiry flag |
| irq | output | 1 | Interrupt request |
| wd_rst | output | 1 | Reset pulse from the watchdog |

## Verification
The assertions check these rules on every cycle:
- a zero count stays at zero;
- a watchdog expiry parks the counter;
- a countdown expiry reloads the written value;
- each flag keeps its value until its own clear arrives;
- a rise of the reset pulse always follows a watchdog expiry;
- the level interrupt follows the enabled countdown flag;
- a countdown clear ends the interrupt pulse.

Some behaviour appears only in the bench's scenarios: the exact tick on which each mode expires, the periodic repeat, the two reset-pulse widths tied to the source index, the pulse length and the effect of ticks on unselected inputs.

// File: rtl/wct_pkg.sv
// Shared types of the watchdog/countdown timer.
// Assumes: mode codes are fixed by the control word layout.
package wct_pkg;
    typedef enum logic [1:0] {
        MODE_HOLD  = 2'b00,
        MODE_CD    = 2'b01,
        MODE_WD    = 2'b10,
        MODE_HOLD2 = 2'b11
    } tmr_mode_e;

    typedef struct packed {
        tmr_mode_e mode;
        logic      pulse;
        logic      cd_ie;
    } tmr_cfg_t;
endpackage

// File: rtl/wct_src_sel.sv
// Picks the tick enable of the configured source.
// Assumes: each tick_en bit is a one-cycle enable in the clk domain.
module wct_src_sel #(
    parameter int N_SRC = 4,
    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] tick_en,
    input  logic [SRC_W-1:0] src,
    output logic             tick
);
    logic [N_SRC-1:0] hit;

    // One match term per source; only the selected index can pass.
    for (genvar i = 0; i < N_SRC; i++) begin : g_hit
        assign hit[i] = tick_en[i] && (src == SRC_W'(i));
    end

    assign tick = |hit;
endmodule

// File: rtl/wct_counter.sv
// Down counter with reload register. Emits one-cycle expiry events.
// Assumes: val_wr takes priority over a coincident tick.
module wct_counter
    import wct_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             val_wr,
    input  logic [CNT_W-1:0] val_wdata,
    input  logic             tick,
    input  tmr_mode_e        mode,
    output logic             wd_evt,
    output logic             cd_evt
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic             run_en;
    logic             step;
    logic             expire;

    assign run_en = (mode == MODE_CD) || (mode == MODE_WD);
    assign step   = tick && run_en && !val_wr && (cnt_q != '0);
    assign expire = step && (cnt_q == CNT_W'(1));
    assign wd_evt = expire && (mode == MODE_WD);
    assign cd_evt = expire && (mode == MODE_CD);

    // Load, count down, reload in countdown mode, park at zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            reload_q <= '0;
        end else if (val_wr) begin
            cnt_q    <= val_wdata;
            reload_q <= val_wdata;
        end else if (step) begin
            if (expire)
                cnt_q <= (mode == MODE_CD) ? reload_q : '0;
            else
                cnt_q <= cnt_q - CNT_W'(1);
        end
    end

    a_r3_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !val_wr) |=> (cnt_q == '0));
    a_r1_load: assert property (@(posedge clk) disable iff (!rst_n)
        val_wr |=> (cnt_q == $past(val_wdata)));
    a_r4_wd_parks: assert property (@(posedge clk) disable iff (!rst_n)
        wd_evt |=> (cnt_q == '0));
    a_r7_reload: assert property (@(posedge clk) disable iff (!rst_n)
        cd_evt |=> (cnt_q == $past(reload_q)));
endmodule

// File: rtl/wct_out_gen.sv
// Flags, countdown interrupt pulse, watchdog reset pulse and irq.
// Assumes: events are one-cycle strobes from wct_counter.
module wct_out_gen #(
    parameter int RST_FAST_CYC = 3,
    parameter int RST_SLOW_CYC = 12,
    parameter int PULSE_CYC    = 5,
    localparam int RST_MAX = (RST_FAST_CYC > RST_SLOW_CYC) ? RST_FAST_CYC : RST_SLOW_CYC,
    localparam int RST_W   = $clog2(RST_MAX + 1),
    localparam int PLS_W   = $clog2(PULSE_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wd_evt,
    input  logic cd_evt,
    input  logic fast_src,
    input  logic val_wr,
    input  logic stat_rd,
    input  logic cd_clr,
    input  logic pulse_mode,
    input  logic cd_ie,
    output logic wd_flag,
    output logic cd_flag,
    output logic irq,
    output logic wd_rst
);
    logic [RST_W-1:0] rst_cnt_q;
    logic [PLS_W-1:0] pls_cnt_q;
    logic             cd_pulse_on;
    logic             cd_irq;

    // Watchdog flag: set by expiry, cleared by reload or status read only.
    always_ff @(posedge clk) begin
        if (!rst_n)                 wd_flag <= 1'b0;
        else if (wd_evt)            wd_flag <= 1'b1;
        else if (val_wr || stat_rd) wd_flag <= 1'b0;
    end

    // Countdown flag: set by expiry, cleared by its own clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)      cd_flag <= 1'b0;
        else if (cd_evt) cd_flag <= 1'b1;
        else if (cd_clr) cd_flag <= 1'b0;
    end

    // Countdown interrupt pulse length counter, cut short by a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                pls_cnt_q <= '0;
        else if (cd_evt)           pls_cnt_q <= PLS_W'(PULSE_CYC);
        else if (cd_clr)           pls_cnt_q <= '0;
        else if (pls_cnt_q != '0)  pls_cnt_q <= pls_cnt_q - PLS_W'(1);
    end

    // Watchdog reset pulse counter; width picked by the source speed.
    always_ff @(posedge clk) begin
        if (!rst_n)               rst_cnt_q <= '0;
        else if (wd_evt)          rst_cnt_q <= fast_src ? RST_W'(RST_FAST_CYC)
                                                        : RST_W'(RST_SLOW_CYC);
        else if (rst_cnt_q != '0) rst_cnt_q <= rst_cnt_q - RST_W'(1);
    end

    assign cd_pulse_on = (pls_cnt_q != '0);
    assign cd_irq      = cd_ie && cd_flag && (!pulse_mode || cd_pulse_on);
    assign irq         = wd_flag || cd_irq;
    assign wd_rst      = (rst_cnt_q != '0);

    a_r5_wd_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_flag && !val_wr && !stat_rd) |=> wd_flag);
    a_r8_cd_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_flag && !cd_clr) |=> cd_flag);
    a_r6_rst_after_wd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wd_rst) |-> $past(wd_evt));
    a_r9_level_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (!pulse_mode && cd_ie && cd_flag) |-> irq);
    a_r10_clear_cuts: assert property (@(posedge clk) disable iff (!rst_n)
        (cd_clr && !cd_evt) |=> !cd_pulse_on);
endmodule

// File: rtl/wct_timer.sv
// Top of the watchdog/countdown timer: control storage and wiring.
// Assumes: all strobes are single-cycle and synchronous to clk.
module wct_timer
    import wct_pkg::*;
#(
    parameter int CNT_W        = 8,
    parameter int N_SRC        = 4,
    parameter int RST_FAST_CYC = 3,
    parameter int RST_SLOW_CYC = 12,
    parameter int PULSE_CYC    = 5,
    localparam int SRC_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [1:0]       ctl_mode,
    input  logic [SRC_W-1:0] ctl_src,
    input  logic             ctl_pulse,
    input  logic             ctl_cd_ie,
    input  logic             val_wr,
    input  logic [CNT_W-1:0] val_wdata,
    input  logic             stat_rd,
    input  logic             cd_clr,
    input  logic [N_SRC-1:0] tick_en,
    output logic             wd_flag,
    output logic             cd_flag,
    output logic             irq,
    output logic             wd_rst
);
    tmr_cfg_t         cfg_q;
    logic [SRC_W-1:0] src_q;
    logic             tick;
    logic             wd_evt;
    logic             cd_evt;

    // Control word storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{mode: MODE_HOLD, pulse: 1'b0, cd_ie: 1'b0};
            src_q <= '0;
        end else if (ctl_wr) begin
            cfg_q <= '{mode: tmr_mode_e'(ctl_mode), pulse: ctl_pulse, cd_ie: ctl_cd_ie};
            src_q <= ctl_src;
        end
    end

    wct_src_sel #(.N_SRC(N_SRC)) u_sel (
        .tick_en (tick_en),
        .src     (src_q),
        .tick    (tick)
    );

    wct_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .val_wr    (val_wr),
        .val_wdata (val_wdata),
        .tick      (tick),
        .mode      (cfg_q.mode),
        .wd_evt    (wd_evt),
        .cd_evt    (cd_evt)
    );

    wct_out_gen #(
        .RST_FAST_CYC (RST_FAST_CYC),
        .RST_SLOW_CYC (RST_SLOW_CYC),
        .PULSE_CYC    (PULSE_CYC)
    ) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .wd_evt     (wd_evt),
        .cd_evt     (cd_evt),
        .fast_src   (src_q == '0),
        .val_wr     (val_wr),
        .stat_rd    (stat_rd),
        .cd_clr     (cd_clr),
        .pulse_mode (cfg_q.pulse),
        .cd_ie      (cfg_q.cd_ie),
        .wd_flag    (wd_flag),
        .cd_flag    (cd_flag),
        .irq        (irq),
        .wd_rst     (wd_rst)
    );
endmodule

// File: tb/wct_timer_tb.sv
module wct_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FAST = 3;
    localparam int SLOW = 12;
    localparam int PLS  = 5;
    localparam logic [1:0] M_HOLD = 2'b00;
    localparam logic [1:0] M_CD   = 2'b01;
    localparam logic [1:0] M_WD   = 2'b10;
    // Each vector: [15:14] mode, [13:12] source, [7:0] count value.
    localparam int NVEC = 6;
    localparam logic [15:0] VEC [NVEC] = '{
        {M_WD, 2'd0, 4'd0, 8'd3},
        {M_WD, 2'd1, 4'd0, 8'd1},
        {M_CD, 2'd2, 4'd0, 8'd5},
        {M_CD, 2'd3, 4'd0, 8'd2},
        {M_WD, 2'd3, 4'd0, 8'd7},
        {M_CD, 2'd0, 4'd0, 8'd4}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [1:0] ctl_mode = '0;
    logic [1:0] ctl_src = '0;
    logic       ctl_pulse = 1'b0;
    logic       ctl_cd_ie = 1'b0;
    logic       val_wr = 1'b0;
    logic [7:0] val_wdata = '0;
    logic       stat_rd = 1'b0;
    logic       cd_clr = 1'b0;
    logic [3:0] tick_en = '0;
    logic       wd_flag, cd_flag, irq, wd_rst;

    int checks = 0;
    int failures = 0;
    logic [1:0] vm;
    int vs, vn, wcnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    wct_timer #(.RST_FAST_CYC(FAST), .RST_SLOW_CYC(SLOW), .PULSE_CYC(PLS)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_mode(ctl_mode),
        .ctl_src(ctl_src), .ctl_pulse(ctl_pulse), .ctl_cd_ie(ctl_cd_ie),
        .val_wr(val_wr), .val_wdata(val_wdata), .stat_rd(stat_rd),
        .cd_clr(cd_clr), .tick_en(tick_en), .wd_flag(wd_flag),
        .cd_flag(cd_flag), .irq(irq), .wd_rst(wd_rst)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_tick(input int idx);
        tick_en = 4'(1 << idx);
        @(negedge clk);
        tick_en = '0;
    endtask

    task automatic set_ctl(input logic [1:0] m, input int s, input bit p, input bit ie);
        ctl_mode = m; ctl_src = 2'(s); ctl_pulse = p; ctl_cd_ie = ie; ctl_wr = 1'b1;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic write_val(input int n);
        val_wdata = 8'(n); val_wr = 1'b1;
        @(negedge clk);
        val_wr = 1'b0;
    endtask

    task automatic status_read();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic clear_cd();
        cd_clr = 1'b1;
        @(negedge clk);
        cd_clr = 1'b0;
    endtask

    task automatic high_len(input bit use_irq, output int len);
        len = 0;
        while ((use_irq ? irq : wd_rst) && len < 100) begin
            len++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk({wd_flag, cd_flag, irq, wd_rst} == 4'b0, "R11 reset outputs",
            {wd_flag, cd_flag, irq, wd_rst}, 0);
        set_ctl(M_HOLD, 0, 0, 1);
        write_val(1);
        repeat (3) do_tick(0);
        chk(!wd_flag && !cd_flag, "R4 hold mode no expiry", {wd_flag, cd_flag}, 0);

        // Vector table: R1 timing, R2 source, R4/R7 expiry, R6 width, R9 irq.
        for (int v = 0; v < NVEC; v++) begin
            vm = VEC[v][15:14];
            vs = int'(VEC[v][13:12]);
            vn = int'(VEC[v][7:0]);
            set_ctl(vm, vs, 0, 1);
            write_val(vn);
            clear_cd();
            for (int k = 1; k < vn; k++) begin
                do_tick((vs + 1) % 4);
                do_tick(vs);
            end
            chk(!wd_flag && !cd_flag, "R1 no expiry before n-th tick",
                {wd_flag, cd_flag}, 0);
            do_tick((vs + 1) % 4);
            do_tick((vs + 3) % 4);
            chk(!wd_flag && !cd_flag, "R2 unselected tick ignored",
                {wd_flag, cd_flag}, 0);
            do_tick(vs);
            if (vm == M_WD) begin
                chk(wd_flag && !cd_flag, "R4 watchdog flag on n-th tick",
                    {wd_flag, cd_flag}, 2);
                chk(irq, "R9 watchdog flag drives irq", irq, 1);
                high_len(0, wcnt);
                chk(wcnt == ((vs == 0) ? FAST : SLOW), "R6 reset pulse width",
                    wcnt, (vs == 0) ? FAST : SLOW);
            end else begin
                chk(cd_flag && !wd_flag && !wd_rst, "R7 countdown flag on n-th tick",
                    {wd_flag, cd_flag, wd_rst}, 2);
                chk(irq, "R9 level countdown irq", irq, 1);
            end
            write_val(0);
            clear_cd();
        end

        // R3 zero value stops the counter in both modes
        set_ctl(M_WD, 1, 0, 1);
        write_val(0);
        repeat (10) do_tick(1);
        chk(!wd_flag && !wd_rst, "R3 zero count in watchdog", {wd_flag, wd_rst}, 0);
        set_ctl(M_CD, 1, 0, 1);
        repeat (10) do_tick(1);
        chk(!cd_flag && !irq, "R3 zero count in countdown", {cd_flag, irq}, 0);

        // R5 watchdog flag clear rules, R4 no repeat
        set_ctl(M_WD, 2, 0, 1);
        write_val(2);
        repeat (2) do_tick(2);
        chk(wd_flag, "R4 watchdog expiry", wd_flag, 1);
        clear_cd();
        chk(wd_flag, "R5 cd_clr leaves watchdog flag", wd_flag, 1);
        high_len(0, wcnt);
        status_read();
        chk(!wd_flag, "R5 status read clears watchdog flag", wd_flag, 0);
        repeat (5) do_tick(2);
        chk(!wd_flag && !wd_rst, "R4 watchdog does not repeat", {wd_flag, wd_rst}, 0);
        write_val(1);
        do_tick(2);
        chk(wd_flag, "R4 watchdog expiry n=1", wd_flag, 1);
        write_val(9);
        chk(!wd_flag, "R5 reload clears watchdog flag", wd_flag, 0);
        high_len(0, wcnt);

        // R7 periodic repeat, R8 clear rules, R9 level irq
        set_ctl(M_CD, 1, 0, 1);
        write_val(3);
        repeat (3) do_tick(1);
        chk(cd_flag && irq, "R7 first countdown period", {cd_flag, irq}, 3);
        status_read();
        chk(cd_flag, "R8 status read leaves countdown flag", cd_flag, 1);
        clear_cd();
        chk(!cd_flag && !irq, "R8 cd_clr clears flag and R9 irq", {cd_flag, irq}, 0);
        repeat (2) do_tick(1);
        chk(!cd_flag, "R7 reload not yet expired", cd_flag, 0);
        do_tick(1);
        chk(cd_flag, "R7 second period expires after n ticks", cd_flag, 1);
        set_ctl(M_CD, 1, 0, 0);
        chk(!irq && cd_flag, "R10 disabled countdown irq", {irq, cd_flag}, 1);
        clear_cd();

        // R10 pulsed interrupt length and shortening
        set_ctl(M_CD, 1, 1, 1);
        repeat (3) do_tick(1);
        high_len(1, wcnt);
        chk(wcnt == PLS, "R10 pulse length", wcnt, PLS);
        chk(cd_flag && !irq, "R10 flag stays after pulse", {cd_flag, irq}, 2);
        clear_cd();
        repeat (3) do_tick(1);
        chk(irq, "R10 pulse starts", irq, 1);
        clear_cd();
        chk(!irq, "R10 clear cuts pulse", irq, 0);
        repeat (PLS) @(negedge clk);
        chk(!irq, "R10 pulse stays cut", irq, 0);

        // R11 reset while flags are set
        set_ctl(M_WD, 0, 0, 1);
        write_val(1);
        do_tick(0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk({wd_flag, cd_flag, irq, wd_rst} == 4'b0, "R11 reset clears state",
            {wd_flag, cd_flag, irq, wd_rst}, 0);
        repeat (3) do_tick(0);
        chk(!wd_flag, "R11 mode held after reset", wd_flag, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule